// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits between a DMA transfer engine and the engine's system bus master port. After each completed read or write access it can hold off the next access for a programmed number of idle clock cycles. This lowers the share of bus bandwidth the engine takes. A two-bit throttle code selects no stall, a short stall of four cycles or a long stall of eight cycles. The single output, `issue_ok`, tells the engine when the next access may be issued.

Two exemptions keep latency low. The first two accesses after a minor loop begins never cause a stall, so a new loop starts at full speed. The final write of a minor loop never causes a stall either, so the loop ends promptly. The block keeps a saturating count of accesses since the last minor-loop start. It does not form addresses and does not choose between channels.

Top module: `dma_bw_throttle`

## Requirements
- R1: In the cycle after synchronous reset is released, `issue_ok` is 1 and no stall is pending.
- R2: With `bw_ctrl` = 2'b00, a completed access (`acc_done` = 1) never drives `issue_ok` low.
- R3: The code 2'b01 is reserved and behaves exactly like 2'b00: no stall.
- R4: With `bw_ctrl` = 2'b10, a non-exempt completed access drives `issue_ok` low for exactly 4 consecutive cycles, starting in the cycle after the clock edge that samples `acc_done`.
- R5: With `bw_ctrl` = 2'b11, a non-exempt completed access drives `issue_ok` low for exactly 8 consecutive cycles, with the same timing as R4.
- R6: The first two accesses completed after a `loop_start` pulse (and after reset) cause no stall, whatever the code. The third access and later ones are throttled.
- R7: An access completed with `last_write` = 1 causes no stall, whatever the code.
- R8: A `loop_start` pulse clears any pending stall, so `issue_ok` is 1 in the following cycle. It also resets the access count used for R6.
- R9: When `loop_start` and `acc_done` are both 1 in the same cycle, `loop_start` wins. The access is neither counted nor throttled, so the next two accesses are still exempt.
- R10: `bw_ctrl` is sampled only on the cycle of `acc_done`. Changing it during a running stall does not change that stall's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bw_ctrl | input | 2 | Throttle code: 00 none, 01 reserved (none), 10 four-cycle stall, 11 eight-cycle stall |
| acc_done | input | 1 | One-cycle strobe that marks a completed bus read or write |
| loop_start | input | 1 | One-cycle strobe that marks the start of a minor loop |
| last_write | input | 1 | Qualifies `acc_done` as the final write of the minor loop |
| issue_ok | output | 1 | Registered; 1 when the engine may issue its next access |

## Verification
Two events can fall in the same cycle: a minor-loop start and an access completion. The bench provokes this by asserting `loop_start` and `acc_done` together in the middle of a long stall, with the long code selected. The collision is judged correct when three things hold. First, `issue_ok` is 1 in the very next cycle, so the pending stall has been dropped. Second, the two accesses that follow still pass without a stall. Third, the third access stalls for the full eight cycles, which shows the colliding access was not counted.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  typedef enum logic [1:0] {
    BW_OFF   = 2'b00,
    BW_RSV   = 2'b01,
    BW_SHORT = 2'b10,
    BW_LONG  = 2'b11
  } bw_code_e;

  // Idle cycles demanded by a code; the reserved code maps to none.
  function automatic int unsigned stall_len(input bw_code_e code,
                                            input int unsigned short_n,
                                            input int unsigned long_n);
    case (code)
      BW_SHORT: stall_len = short_n;
      BW_LONG:  stall_len = long_n;
      default:  stall_len = 0;
    endcase
  endfunction

endpackage

// File: rtl/bwt_startup_tracker.sv
module bwt_startup_tracker #(
  parameter int unsigned EXEMPT_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_start,
  input  logic acc_done,
  output logic exempt
);
  localparam int unsigned IDX_W = $clog2(EXEMPT_N + 1);

  logic [IDX_W-1:0] idx;

  assign exempt = (idx < IDX_W'(EXEMPT_N));

  always_ff @(posedge clk) begin
    if (rst || loop_start)
      idx <= '0;
    else if (acc_done && exempt)
      idx <= idx + 1'b1;
  end

  // R6: the access count saturates at the exemption limit.
  a_r6_idx_bounded: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(EXEMPT_N));

  // R8: a loop start reopens the startup window.
  a_r8_window_reset: assert property (@(posedge clk) disable iff (rst)
    loop_start |=> exempt);

endmodule

// File: rtl/bwt_stall_counter.sv
module bwt_stall_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             issue_ok
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (clr)
      cnt_nxt = '0;
    else if (load)
      cnt_nxt = load_val;
    else if (cnt != '0)
      cnt_nxt = cnt - 1'b1;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      issue_ok <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      issue_ok <= (cnt_nxt == '0);
    end
  end

  // R4: with no new event, a pending stall drains by exactly one per cycle.
  a_r4_drain_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !clr && !load) |=> (cnt == $past(cnt) - 1'b1));

  // R8: clearing always re-enables issue on the next cycle.
  a_r8_clear_ready: assert property (@(posedge clk) disable iff (rst)
    clr |=> issue_ok);

endmodule

// File: rtl/dma_bw_throttle.sv
module dma_bw_throttle #(
  parameter int unsigned STALL_SHORT = 4,
  parameter int unsigned STALL_LONG  = 8,
  parameter int unsigned EXEMPT_N    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bw_ctrl,
  input  logic       acc_done,
  input  logic       loop_start,
  input  logic       last_write,
  output logic       issue_ok
);
  import bwt_pkg::*;

  localparam int unsigned CNT_W = $clog2(STALL_LONG + 1);

  logic             exempt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  bw_code_e         code;

  assign code = bw_code_e'(bw_ctrl);
  assign load = acc_done && !loop_start;

  always_comb begin
    if (exempt || last_write)
      load_val = '0;
    else
      load_val = CNT_W'(stall_len(code, STALL_SHORT, STALL_LONG));
  end

  bwt_startup_tracker #(.EXEMPT_N(EXEMPT_N)) u_track (
    .clk        (clk),
    .rst        (rst),
    .loop_start (loop_start),
    .acc_done   (acc_done),
    .exempt     (exempt)
  );

  bwt_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (loop_start),
    .load     (load),
    .load_val (load_val),
    .issue_ok (issue_ok)
  );

  // R2 / R3: codes with a clear upper bit never stall.
  a_r2_no_stall_code: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !bw_ctrl[1]) |=> issue_ok);

  // R7: the final write of a loop never stalls.
  a_r7_last_write: assert property (@(posedge clk) disable iff (rst)
    (acc_done && last_write) |=> issue_ok);

  // R6: accesses inside the startup window never stall.
  a_r6_startup: assert property (@(posedge clk) disable iff (rst)
    (acc_done && exempt) |=> issue_ok);

  // R5: a throttled access under a stalling code holds off issue.
  a_r5_stall_begins: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !loop_start && !exempt && !last_write && bw_ctrl[1]) |=> !issue_ok);

endmodule

// File: tb/dma_bw_throttle_bench.sv
module dma_bw_throttle_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bw_ctrl = 2'b00;
  logic       acc_done = 1'b0;
  logic       loop_start = 1'b0;
  logic       last_write = 1'b0;
  logic       issue_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_bw_throttle u_dma_bw_throttle (
    .clk(clk), .rst(rst), .bw_ctrl(bw_ctrl), .acc_done(acc_done),
    .loop_start(loop_start), .last_write(last_write), .issue_ok(issue_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One-cycle access strobe, then count the low cycles of issue_ok.
  task automatic access(input logic [1:0] code, input logic lw,
                        input int exp, input string req);
    int lows = 0;
    @(negedge clk);
    bw_ctrl = code; last_write = lw; acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0; last_write = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (issue_ok) break;
      lows++;
      @(negedge clk);
    end
    check(req, lows, exp);
  endtask

  task automatic start_loop();
    @(negedge clk);
    loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(issue_ok), 1);
  endtask

  task automatic t_codes();
    start_loop();
    access(2'b11, 1'b0, 0, "R6 first access exempt");
    access(2'b11, 1'b0, 0, "R6 second access exempt");
    access(2'b00, 1'b0, 0, "R2 code 00 no stall");
    access(2'b01, 1'b0, 0, "R3 reserved code no stall");
    access(2'b10, 1'b0, 4, "R4 short stall");
    access(2'b11, 1'b0, 8, "R5 long stall");
    access(2'b11, 1'b1, 0, "R7 last write exempt");
    access(2'b10, 1'b1, 0, "R7 last write exempt short");
  endtask

  task automatic t_after_reset_window();
    t_reset();
    access(2'b10, 1'b0, 0, "R6 exempt after reset 1");
    access(2'b10, 1'b0, 0, "R6 exempt after reset 2");
    access(2'b10, 1'b0, 4, "R6 third access throttled");
  endtask

  task automatic t_loop_clears();
    @(negedge clk);
    bw_ctrl = 2'b11; acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    @(negedge clk);
    check("R8 stall pending", int'(issue_ok), 0);
    loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
    check("R8 loop start clears stall", int'(issue_ok), 1);
    access(2'b11, 1'b0, 0, "R8 window reset 1");
    access(2'b11, 1'b0, 0, "R8 window reset 2");
    access(2'b11, 1'b0, 8, "R8 throttled after window");
  endtask

  task automatic t_collision();
    @(negedge clk);
    bw_ctrl = 2'b11; acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    @(negedge clk);
    loop_start = 1'b1; acc_done = 1'b1;
    @(negedge clk);
    loop_start = 1'b0; acc_done = 1'b0;
    check("R9 collision leaves issue open", int'(issue_ok), 1);
    access(2'b11, 1'b0, 0, "R9 access after collision 1");
    access(2'b11, 1'b0, 0, "R9 access after collision 2");
    access(2'b11, 1'b0, 8, "R9 third access stalls");
  endtask

  task automatic t_code_change();
    int lows = 0;
    @(negedge clk);
    bw_ctrl = 2'b11; acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0; bw_ctrl = 2'b00;
    for (int i = 0; i < 20; i++) begin
      if (issue_ok) break;
      lows++;
      @(negedge clk);
      bw_ctrl = 2'b10;
    end
    check("R10 code change mid stall", lows, 8);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_codes();
    t_after_reset_window();
    t_loop_clears();
    t_collision();
    t_code_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule